// File: doc/BRIEF.md
# UART Interrupt and Line-Status Controller

This block sits beside the receive and transmit FIFOs of a 16550-style UART with 32-entry queues. It keeps the line-status byte the host reads, holds the four-bit interrupt enable mask, and drives the interrupt request line. The FIFOs, shifters and baud logic stay outside. They report their fill levels, the error tags of the head character and of each arriving character, an overrun pulse and a shift-register-empty flag. The host writes the enable mask and reads the status byte through single-cycle strobes.

Every status bit and every receive-side source is registered, so each one follows its inputs after one clock edge. The interrupt line is registered once more on top of that. A small state machine tracks the transmit-ready source. Its states are `TXI_OFF` (source disabled), `TXI_WAIT` (enabled, transmit side above threshold) and `TXI_FIRE` (enabled and below threshold, source pending). Writing a 1 to the enable bit moves `TXI_OFF` to `TXI_FIRE` or to `TXI_WAIT`, depending on the transmit level. `TXI_WAIT` moves to `TXI_FIRE` when the level drops under the threshold, and `TXI_FIRE` moves back to `TXI_WAIT` when it rises again. Writing a 0 to the enable bit returns either active state to `TXI_OFF`.

When the FIFOs are enabled and the mask is all zero, the block is in polled mode. The status byte keeps updating and the interrupt line stays low.

Top module: `uart_irq_lsr_ctrl`

## Requirements
- R1: After reset the enable mask is 0, the status byte is 0x60, the pending flags are 0 and the interrupt line is low.
- R2: Status bit 0 (data ready) equals (rx_level != 0), sampled one clock edge earlier.
- R3: Status bit 1 (overrun) sets on an rx_overrun pulse and stays set until a status read. If a read and an overrun pulse come in the same cycle, the bit stays set.
- R4: With err_early = 0, status bits 4..2 show the registered head error tag: bit 2 = rx_head_err[0] (parity), bit 3 = rx_head_err[1] (framing), bit 4 = rx_head_err[2] (break). They read 0 when the receive FIFO is empty.
- R5: With err_early = 1, status bits 4..2 show an accumulated tag. Each rx_push ORs rx_push_err into it, using the same bit mapping as R4. A status read clears the accumulated tag, but a push in the same cycle still adds its tag.
- R6: Status bit 5 = (tx_level == 0). Status bit 6 = (tx_level == 0) and tx_shift_empty. Status bit 7 = rx_fifo_err.
- R7: Pending bit 0 (receive data) equals ier[0] AND a registered hit. With fifo_en the hit is rx_level >= threshold; without it the hit is rx_level != 0. trig_sel codes 0, 1, 2, 3 select thresholds 8, 16, 24, 28.
- R8: Pending bit 1 (transmit ready) equals ier[1] AND low. With fifo_en, low means tx_level < threshold, using the same trig_sel encoding as R7; without fifo_en, low means tx_level == 0. An enable write that sets ier[1] while low holds makes the flag 1 right after that edge.
- R9: Pending bit 2 (line status) equals ier[2] AND the OR of status bits 4..1.
- R10: irq equals the OR of the pending flags one edge earlier. With the mask at 0 (polled mode), irq stays low.
- R11: An ier_wr strobe loads ier_wdata[3:0] into the mask, and ier_out reads the mask back. Bit 3 is stored but drives no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Trigger threshold code |
| err_early | input | 1 | Report receive errors on FIFO entry instead of at the head |
| rx_level | input | 6 | Receive FIFO fill level |
| rx_head_err | input | 3 | Error tag of the head character {break, framing, parity} |
| rx_fifo_err | input | 1 | At least one stored receive character carries an error |
| rx_push | input | 1 | Character written into the receive FIFO this cycle |
| rx_push_err | input | 3 | Error tag of the character being written |
| rx_overrun | input | 1 | Overrun pulse from the receiver |
| tx_level | input | 6 | Transmit FIFO fill level |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| ier_wr | input | 1 | Enable-mask write strobe |
| ier_wdata | input | 4 | Enable-mask write data |
| lsr_rd | input | 1 | Status-byte read strobe |
| ier_out | output | 4 | Enable mask readback |
| lsr_out | output | 8 | Line-status byte |
| pend_out | output | 3 | Enabled pending sources {line status, transmit, receive} |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision of host strobes with receiver events in one cycle. Examples are a status read in the same cycle as an overrun pulse, or a read that clears the accumulated early-error tag while a faulty character is being pushed. A mask write that enables the transmit source while the transmit side is already under threshold is similar. Random stimulus sets each strobe with fixed probabilities, so these overlaps happen often across a few thousand cycles. Directed sequences then force each collision, the exact threshold boundaries (levels 7/8 and 27/28), and polled mode with data present.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        TXI_OFF  = 2'd0,
        TXI_WAIT = 2'd1,
        TXI_FIRE = 2'd2
    } txi_state_t;

    // Threshold in entries for a trigger code: quarter steps, last one at seven eighths
    function automatic int trig_level(input logic [1:0] sel, input int depth);
        int v;
        unique case (sel)
            2'd0:    v = depth / 4;
            2'd1:    v = depth / 2;
            2'd2:    v = (3 * depth) / 4;
            default: v = depth - depth / 8;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker #(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_early,
    input  logic [LW-1:0] rx_level,
    input  logic [2:0]    rx_head_err,
    input  logic          rx_fifo_err,
    input  logic          rx_push,
    input  logic [2:0]    rx_push_err,
    input  logic          rx_overrun,
    input  logic [LW-1:0] tx_level,
    input  logic          tx_shift_empty,
    input  logic          lsr_rd,
    output logic [7:0]    lsr
);

    localparam logic [7:0] LSR_RESET = 8'h60;

    logic [2:0] early_q;
    logic [2:0] early_d;
    logic [2:0] head_d;
    logic       ovr_d;
    logic       tx_empty;
    logic [7:0] lsr_d;

    always_comb begin
        early_d  = (lsr_rd ? 3'b000 : early_q) | (rx_push ? rx_push_err : 3'b000);
        head_d   = (rx_level != '0) ? rx_head_err : 3'b000;
        ovr_d    = rx_overrun | (lsr[1] & ~lsr_rd);
        tx_empty = (tx_level == '0);
        lsr_d    = {rx_fifo_err,
                    tx_empty & tx_shift_empty,
                    tx_empty,
                    err_early ? early_d : head_d,
                    ovr_d,
                    rx_level != '0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= 3'b000;
            lsr     <= LSR_RESET;
        end else begin
            early_q <= early_d;
            lsr     <= lsr_d;
        end
    end

endmodule

// File: rtl/uart_txi_fsm.sv
module uart_txi_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ier_wr,
    input  logic ier_wbit,
    input  logic tx_low,
    output logic tx_pend
);

    txi_state_t state;
    txi_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TXI_OFF: begin
                if (ier_wr && ier_wbit)
                    state_nxt = tx_low ? TXI_FIRE : TXI_WAIT;
            end
            TXI_WAIT: begin
                if (ier_wr && !ier_wbit) state_nxt = TXI_OFF;
                else if (tx_low)         state_nxt = TXI_FIRE;
            end
            TXI_FIRE: begin
                if (ier_wr && !ier_wbit) state_nxt = TXI_OFF;
                else if (!tx_low)        state_nxt = TXI_WAIT;
            end
            default: state_nxt = TXI_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TXI_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        tx_pend = (state == TXI_FIRE);
    end

endmodule

// File: rtl/uart_irq_lsr_ctrl.sv
module uart_irq_lsr_ctrl #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic          err_early,
    input  logic [LW-1:0] rx_level,
    input  logic [2:0]    rx_head_err,
    input  logic          rx_fifo_err,
    input  logic          rx_push,
    input  logic [2:0]    rx_push_err,
    input  logic          rx_overrun,
    input  logic [LW-1:0] tx_level,
    input  logic          tx_shift_empty,
    input  logic          ier_wr,
    input  logic [3:0]    ier_wdata,
    input  logic          lsr_rd,
    output logic [3:0]    ier_out,
    output logic [7:0]    lsr_out,
    output logic [2:0]    pend_out,
    output logic          irq
);

    localparam int SRC_N = 3;

    logic [3:0]       ier_q;
    logic [LW-1:0]    thr;
    logic             rx_hit_d;
    logic             rx_hit_q;
    logic             tx_low;
    logic             tx_pend;
    logic [SRC_N-1:0] pend;

    assign thr = LW'(uart_irq_pkg::trig_level(trig_sel, DEPTH));

    always_comb begin
        rx_hit_d = fifo_en ? (rx_level >= thr) : (rx_level != '0);
        tx_low   = fifo_en ? (tx_level <  thr) : (tx_level == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q    <= 4'h0;
            rx_hit_q <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (ier_wr) ier_q <= ier_wdata;
            rx_hit_q <= rx_hit_d;
            irq      <= |pend;
        end
    end

    uart_lsr_tracker #(.LW(LW)) u_lsr (
        .clk            (clk),
        .rst_n          (rst_n),
        .err_early      (err_early),
        .rx_level       (rx_level),
        .rx_head_err    (rx_head_err),
        .rx_fifo_err    (rx_fifo_err),
        .rx_push        (rx_push),
        .rx_push_err    (rx_push_err),
        .rx_overrun     (rx_overrun),
        .tx_level       (tx_level),
        .tx_shift_empty (tx_shift_empty),
        .lsr_rd         (lsr_rd),
        .lsr            (lsr_out)
    );

    uart_txi_fsm u_txi (
        .clk      (clk),
        .rst_n    (rst_n),
        .ier_wr   (ier_wr),
        .ier_wbit (ier_wdata[1]),
        .tx_low   (tx_low),
        .tx_pend  (tx_pend)
    );

    always_comb begin
        pend[0] = ier_q[0] & rx_hit_q;
        pend[1] = tx_pend;
        pend[2] = ier_q[2] & (|lsr_out[4:1]);
    end

    assign pend_out = pend;
    assign ier_out  = ier_q;

endmodule

// File: rtl/uart_irq_lsr_ctrl_chk.sv
module uart_irq_lsr_ctrl_chk #(
    parameter int LW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] rx_level,
    input logic          rx_overrun,
    input logic [LW-1:0] tx_level,
    input logic          ier_wr,
    input logic [3:0]    ier_wdata,
    input logic          lsr_rd,
    input logic [3:0]    ier_out,
    input logic [7:0]    lsr_out,
    input logic [2:0]    pend_out,
    input logic          irq
);

    p_data_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (lsr_out[0] == ($past(rx_level) != '0)));

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> lsr_out[1]);

    p_overrun_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_overrun) |=> !lsr_out[1]);

    p_tx_enable_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && ier_wdata[1] && tx_level == '0) |=> pend_out[1]);

    p_ls_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_out[2] |-> (ier_out[2] && (|lsr_out[4:1])));

    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == (|$past(pend_out))));

    p_polled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_out == 4'h0) |=> !irq);

endmodule

bind uart_irq_lsr_ctrl uart_irq_lsr_ctrl_chk #(.LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_level   (rx_level),
    .rx_overrun (rx_overrun),
    .tx_level   (tx_level),
    .ier_wr     (ier_wr),
    .ier_wdata  (ier_wdata),
    .lsr_rd     (lsr_rd),
    .ier_out    (ier_out),
    .lsr_out    (lsr_out),
    .pend_out   (pend_out),
    .irq        (irq)
);

// File: tb/uart_irq_lsr_ctrl_test.sv
module uart_irq_lsr_ctrl_test;

    localparam int DEPTH = 32;
    localparam int LW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0;
    logic [1:0]    trig_sel = 2'd0;
    logic          err_early = 1'b0;
    logic [LW-1:0] rx_level = '0;
    logic [2:0]    rx_head_err = 3'b0;
    logic          rx_fifo_err = 1'b0;
    logic          rx_push = 1'b0;
    logic [2:0]    rx_push_err = 3'b0;
    logic          rx_overrun = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic          tx_shift_empty = 1'b1;
    logic          ier_wr = 1'b0;
    logic [3:0]    ier_wdata = 4'h0;
    logic          lsr_rd = 1'b0;
    logic [3:0]    ier_out;
    logic [7:0]    lsr_out;
    logic [2:0]    pend_out;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_ier;
    logic [7:0] m_lsr;
    logic [2:0] m_early;
    logic       m_rxhit;
    logic       m_txpend;
    logic       m_irq;

    always #2 clk = ~clk;

    uart_irq_lsr_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .err_early(err_early), .rx_level(rx_level), .rx_head_err(rx_head_err),
        .rx_fifo_err(rx_fifo_err), .rx_push(rx_push), .rx_push_err(rx_push_err),
        .rx_overrun(rx_overrun), .tx_level(tx_level), .tx_shift_empty(tx_shift_empty),
        .ier_wr(ier_wr), .ier_wdata(ier_wdata), .lsr_rd(lsr_rd),
        .ier_out(ier_out), .lsr_out(lsr_out), .pend_out(pend_out), .irq(irq)
    );

    function automatic int thr_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 24;
            default: return 28;
        endcase
    endfunction

    function automatic logic [2:0] pend_of(input logic [3:0] ie, input logic [7:0] ls,
                                           input logic rh, input logic tp);
        return {ie[2] & (|ls[4:1]), tp, ie[0] & rh};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge with current inputs, predict, then compare at the falling edge
    task automatic step(input string tag);
        logic [3:0] ier_n;
        logic [2:0] early_n, head_n;
        logic [7:0] lsr_n;
        logic       irq_n, rxhit_n, txlow, txpend_n, temp;
        irq_n    = |pend_of(m_ier, m_lsr, m_rxhit, m_txpend);
        ier_n    = ier_wr ? ier_wdata : m_ier;
        early_n  = (lsr_rd ? 3'b0 : m_early) | (rx_push ? rx_push_err : 3'b0);
        head_n   = (rx_level != 0) ? rx_head_err : 3'b0;
        temp     = (tx_level == 0);
        lsr_n    = {rx_fifo_err, temp & tx_shift_empty, temp,
                    err_early ? early_n : head_n,
                    rx_overrun | (m_lsr[1] & ~lsr_rd), rx_level != 0};
        rxhit_n  = fifo_en ? (int'(rx_level) >= thr_of(trig_sel)) : (rx_level != 0);
        txlow    = fifo_en ? (int'(tx_level) <  thr_of(trig_sel)) : (tx_level == 0);
        txpend_n = ier_n[1] & txlow;
        @(posedge clk);
        m_ier = ier_n; m_early = early_n; m_lsr = lsr_n;
        m_rxhit = rxhit_n; m_txpend = txpend_n; m_irq = irq_n;
        @(negedge clk);
        chk({tag, " R11 ier"}, ier_out, m_ier);
        chk({tag, " R2 R3 R4 R5 R6 lsr"}, lsr_out, m_lsr);
        chk({tag, " R7 R8 R9 pend"}, pend_out, pend_of(m_ier, m_lsr, m_rxhit, m_txpend));
        chk({tag, " R10 irq"}, irq, m_irq);
    endtask

    task automatic idle_strobes();
        ier_wr = 0; lsr_rd = 0; rx_push = 0; rx_overrun = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        m_ier = 0; m_lsr = 8'h60; m_early = 0; m_rxhit = 0; m_txpend = 0; m_irq = 0;
        chk("R1 ier", ier_out, 0);
        chk("R1 lsr", lsr_out, 8'h60);
        chk("R1 pend", pend_out, 0);
        chk("R1 irq", irq, 0);

        // R8 enable transmit source while already empty: pending right away
        tx_level = 0; ier_wr = 1; ier_wdata = 4'b0010;
        step("R8 immediate");
        chk("R8 tx pend now", pend_out[1], 1);
        idle_strobes();
        step("R10 irq next");
        chk("R10 irq after tx pend", irq, 1);
        tx_level = 5; step("R8 not empty nofifo");
        chk("R8 cleared when filled", pend_out[1], 0);

        // R7 threshold boundaries in FIFO mode
        fifo_en = 1; ier_wr = 1; ier_wdata = 4'b0101; step("R11 write");
        idle_strobes();
        trig_sel = 0; rx_level = 7;  step("R7 below 8");
        chk("R7 level 7 code0", pend_out[0], 0);
        rx_level = 8;  step("R7 at 8");
        chk("R7 level 8 code0", pend_out[0], 1);
        trig_sel = 3; rx_level = 27; step("R7 below 28");
        chk("R7 level 27 code3", pend_out[0], 0);
        rx_level = 28; step("R7 at 28");
        chk("R7 level 28 code3", pend_out[0], 1);

        // R3 overrun with simultaneous read keeps bit set, later read clears
        rx_overrun = 1; lsr_rd = 1; step("R3 collide");
        chk("R3 set wins", lsr_out[1], 1);
        idle_strobes(); lsr_rd = 1; step("R3 clear");
        chk("R3 read clears", lsr_out[1], 0);
        idle_strobes();

        // R5 early error: read and faulty push in the same cycle
        err_early = 1; rx_push = 1; rx_push_err = 3'b010; step("R5 push");
        chk("R5 framing bit", lsr_out[3], 1);
        chk("R9 ls pending", pend_out[2], 1);
        rx_push = 1; rx_push_err = 3'b100; lsr_rd = 1; step("R5 read+push");
        chk("R5 only new tag", lsr_out[4:2], 3'b100);
        idle_strobes(); lsr_rd = 1; step("R5 cleared");
        chk("R5 empty after read", lsr_out[4:2], 0);
        idle_strobes();

        // R4 head tag, zero when empty
        err_early = 0; rx_level = 3; rx_head_err = 3'b001; step("R4 head");
        chk("R4 parity", lsr_out[2], 1);
        rx_level = 0; step("R4 empty");
        chk("R4 empty hides tag", lsr_out[4:2], 0);

        // R10 polled mode: data present, mask zero
        ier_wr = 1; ier_wdata = 0; rx_level = 30; rx_overrun = 1; step("R10 polled");
        idle_strobes(); step("R10 polled2");
        chk("R10 polled no irq", irq, 0);
        chk("R2 data ready polled", lsr_out[0], 1);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            fifo_en        = ($urandom % 4) != 0;
            if (($urandom % 16) == 0) trig_sel = 2'($urandom % 4);
            if (($urandom % 32) == 0) err_early = ~err_early;
            rx_level       = LW'($urandom % (DEPTH + 1));
            rx_head_err    = 3'($urandom % 8);
            rx_fifo_err    = ($urandom % 3) == 0;
            rx_push        = ($urandom % 3) == 0;
            rx_push_err    = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'b0;
            rx_overrun     = ($urandom % 20) == 0;
            tx_level       = (($urandom % 4) == 0) ? '0 : LW'($urandom % (DEPTH + 1));
            tx_shift_empty = $urandom % 2;
            ier_wr         = ($urandom % 10) == 0;
            ier_wdata      = 4'($urandom % 16);
            lsr_rd         = ($urandom % 6) == 0;
            step("R6 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule